// File: doc/BRIEF.md
# UART Interrupt Mask and Routing

This block holds the interrupt state of a serial port. Event sources (receive level, transmit space, receive timeout, modem line changes, line errors) pulse per-bit set strobes. The strobes latch into an 11-bit raw status vector. Software controls an 11-bit enable mask and clears raw bits by writing ones. The masked status drives six interrupt lines: one that combines every enabled source, three dedicated lines for receive, transmit and receive timeout, one shared line for the four modem-status sources and one shared line for the four error sources.

Register access uses a 2-bit select, a write strobe with write data, and a combinational read-data port. The address decode that produces the select lives outside this block. A write of a character into the transmit data path is reported on its own input and raises the transmit source.

Top module: `uirq_router`

## Requirements
- R1: Source bit positions are fixed: ring 0, clear-to-send 1, carrier 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing error 7, parity error 8, break 9, overrun 10.
- R2: A write with `regSel`=0 replaces the entire enable mask with `regWrData`, and a read at select 0 returns the mask.
- R3: A read at select 1 returns the raw vector. A read at select 2 returns the raw vector ANDed with the mask.
- R4: A write with `regSel`=3 clears every raw bit where `regWrData` has a one and leaves the other bits unchanged. A read at select 3 returns zero.
- R5: Writes at select 1 and select 2 change neither the raw vector nor the mask.
- R6: Each bit of `evtSet` that is high at a clock edge sets the matching raw bit. A high `txDataWr` sets raw bit 5.
- R7: When a set strobe and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R8: `irqAll` is the OR of all masked bits.
- R9: `irqRx`, `irqTx` and `irqTmo` follow masked bits 4, 5 and 6.
- R10: `irqModem` is the OR of masked bits 0 to 3. `irqErr` is the OR of masked bits 7 to 10.
- R11: All six interrupt outputs are registered. They change one clock edge after the raw or mask change that causes them.
- R12: Reset (`rstN` low) clears the raw vector, the mask and all interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 mask, 1 raw, 2 masked, 3 clear |
| regWrData | input | 11 | Register write data |
| regRdData | output | 11 | Read data for the current select |
| evtSet | input | 11 | Per-source set strobes |
| txDataWr | input | 1 | Character written to transmit data |
| irqAll | output | 1 | Combined interrupt |
| irqRx | output | 1 | Receive interrupt |
| irqTx | output | 1 | Transmit interrupt |
| irqTmo | output | 1 | Receive-timeout interrupt |
| irqModem | output | 1 | Modem-status interrupt |
| irqErr | output | 1 | Error interrupt |

## Verification
An event strobe and a software write-one-to-clear can land on the same raw bit in the same cycle. The bench provokes this by driving `evtSet` and a clear write together in one cycle. The clear covers the struck bit and a neighbouring bit. The result is judged by reading back the raw vector: the struck bit must still be set and the neighbour must be cleared. A second overlap pairs a mask write with a new event. For that case the bench checks that the outputs still lag both changes by exactly one edge.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int NUM_SRC   = 11;
  localparam int NUM_LINES = 6;
  localparam int SEL_W     = 2;

  // source positions
  localparam int BIT_RI  = 0;
  localparam int BIT_CTS = 1;
  localparam int BIT_DCD = 2;
  localparam int BIT_DSR = 3;
  localparam int BIT_RX  = 4;
  localparam int BIT_TX  = 5;
  localparam int BIT_RT  = 6;
  localparam int BIT_FE  = 7;
  localparam int BIT_PE  = 8;
  localparam int BIT_BE  = 9;
  localparam int BIT_OE  = 10;

  // output line indices
  localparam int LINE_ALL   = 0;
  localparam int LINE_RX    = 1;
  localparam int LINE_TX    = 2;
  localparam int LINE_TMO   = 3;
  localparam int LINE_MODEM = 4;
  localparam int LINE_ERR   = 5;

  typedef logic [NUM_SRC-1:0] srcVec_t;

  localparam srcVec_t MODEM_GROUP = srcVec_t'((1 << BIT_RI) | (1 << BIT_CTS) |
                                             (1 << BIT_DCD) | (1 << BIT_DSR));
  localparam srcVec_t ERR_GROUP   = srcVec_t'((1 << BIT_FE) | (1 << BIT_PE) |
                                             (1 << BIT_BE) | (1 << BIT_OE));

  localparam srcVec_t LINE_GROUP [NUM_LINES] = '{
    {NUM_SRC{1'b1}},
    srcVec_t'(1 << BIT_RX),
    srcVec_t'(1 << BIT_TX),
    srcVec_t'(1 << BIT_RT),
    MODEM_GROUP,
    ERR_GROUP
  };

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK   = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_CLEAR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    maskWrEn;
    logic    clrEn;
    srcVec_t wrData;
    srcVec_t setVec;
  } strobe_t;

endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic             regWr,
  input  logic [SEL_W-1:0] regSel,
  input  srcVec_t          regWrData,
  input  srcVec_t          evtSet,
  input  logic             txDataWr,
  input  srcVec_t          rawQ,
  input  srcVec_t          maskQ,
  output strobe_t          strb,
  output srcVec_t          regRdData
);

  regSel_e sel;
  srcVec_t txSet;

  assign sel = regSel_e'(regSel);

  always_comb begin
    txSet = '0;
    txSet[BIT_TX] = txDataWr;
  end

  // writes at raw and masked selects decode to no strobe at all
  always_comb begin
    strb          = '0;
    strb.wrData   = regWrData;
    strb.setVec   = evtSet | txSet;
    strb.maskWrEn = regWr && (sel == SEL_MASK);
    strb.clrEn    = regWr && (sel == SEL_CLEAR);
  end

  always_comb begin
    unique case (sel)
      SEL_MASK:   regRdData = maskQ;
      SEL_RAW:    regRdData = rawQ;
      SEL_MASKED: regRdData = rawQ & maskQ;
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/uirq_dpath.sv
module uirq_dpath
  import uirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  output srcVec_t              rawQ,
  output srcVec_t              maskQ,
  output logic [NUM_LINES-1:0] lineQ
);

  srcVec_t              rawNext;
  srcVec_t              maskNext;
  srcVec_t              clrVec;
  srcVec_t              maskedNow;
  logic [NUM_LINES-1:0] lineNext;
  logic                 pastValid;

  // a set on the same bit overrides the clear
  always_comb begin
    clrVec   = strb.clrEn ? strb.wrData : '0;
    rawNext  = (rawQ & ~clrVec) | strb.setVec;
    maskNext = strb.maskWrEn ? strb.wrData : maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= '0;
      maskQ <= '0;
    end else begin
      rawQ  <= rawNext;
      maskQ <= maskNext;
    end
  end

  assign maskedNow = rawQ & maskQ;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign lineNext[g] = |(maskedNow & LINE_GROUP[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineQ <= '0;
    else       lineQ <= lineNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && |strb.setVec) |=> ((rawQ & $past(strb.setVec)) == $past(strb.setVec))); // R7

  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && strb.clrEn) |=> ((rawQ & $past(strb.wrData & ~strb.setVec)) == '0)); // R4

  AST_MASK_REPLACE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && strb.maskWrEn) |=> (maskQ == $past(strb.wrData))); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |=> ((rawQ & ~$past(rawQ) & ~$past(strb.setVec)) == '0)); // R6

  AST_COMBINED_LAG: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |=> (lineQ[LINE_ALL] == $past(|(rawQ & maskQ)))); // R11

endmodule

// File: rtl/uirq_router.sv
module uirq_router
  import uirq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regSel,
  input  logic [10:0] regWrData,
  output logic [10:0] regRdData,
  input  logic [10:0] evtSet,
  input  logic        txDataWr,
  output logic        irqAll,
  output logic        irqRx,
  output logic        irqTx,
  output logic        irqTmo,
  output logic        irqModem,
  output logic        irqErr
);

  strobe_t              strb;
  srcVec_t              rawQ;
  srcVec_t              maskQ;
  logic [NUM_LINES-1:0] lineQ;

  uirq_ctrl u_ctrl (
    .regWr     (regWr),
    .regSel    (regSel),
    .regWrData (regWrData),
    .evtSet    (evtSet),
    .txDataWr  (txDataWr),
    .rawQ      (rawQ),
    .maskQ     (maskQ),
    .strb      (strb),
    .regRdData (regRdData)
  );

  uirq_dpath u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rawQ  (rawQ),
    .maskQ (maskQ),
    .lineQ (lineQ)
  );

  assign irqAll   = lineQ[LINE_ALL];
  assign irqRx    = lineQ[LINE_RX];
  assign irqTx    = lineQ[LINE_TX];
  assign irqTmo   = lineQ[LINE_TMO];
  assign irqModem = lineQ[LINE_MODEM];
  assign irqErr   = lineQ[LINE_ERR];

  AST_GROUP_IMPLIES_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (irqRx || irqTx || irqTmo || irqModem || irqErr) |-> irqAll); // R8

endmodule

// File: tb/uirq_router_tb.sv
module uirq_router_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [10:0] regWrData = '0;
  logic [10:0] regRdData;
  logic [10:0] evtSet = '0;
  logic        txDataWr = 1'b0;
  logic        irqAll, irqRx, irqTx, irqTmo, irqModem, irqErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  uirq_router u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .evtSet(evtSet),
    .txDataWr(txDataWr), .irqAll(irqAll), .irqRx(irqRx), .irqTx(irqTx),
    .irqTmo(irqTmo), .irqModem(irqModem), .irqErr(irqErr)
  );

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  // expected {all,rx,tx,tmo,modem,err} from the requirements
  function automatic logic [10:0] expLines(input logic [10:0] raw, input logic [10:0] msk);
    logic [10:0] m = raw & msk;
    return {5'b0, |m, m[4], m[5], m[6], |m[3:0], |m[10:7]};
  endfunction

  function automatic logic [10:0] outLines();
    return {5'b0, irqAll, irqRx, irqTx, irqTmo, irqModem, irqErr};
  endfunction

  task automatic regWrite(input logic [1:0] sel, input logic [10:0] data);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [10:0] data);
    regSel = sel;
    #0.5;
    data = regRdData;
  endtask

  task automatic pulseSet(input logic [10:0] bits);
    @(negedge clk);
    evtSet = bits;
    @(negedge clk);
    evtSet = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [10:0] d;
    regRead(2'd0, d); check("R12 mask after reset", d, 11'h000);
    regRead(2'd1, d); check("R12 raw after reset", d, 11'h000);
    check("R12 outputs after reset", outLines(), 11'h000);
  endtask

  task automatic t_mask();
    logic [10:0] d;
    regWrite(2'd0, 11'h5A5);
    regRead(2'd0, d); check("R2 mask readback", d, 11'h5A5);
    regWrite(2'd0, 11'h00F);
    regRead(2'd0, d); check("R2 mask fully replaced", d, 11'h00F);
  endtask

  task automatic t_events();
    logic [10:0] d;
    regWrite(2'd3, 11'h7FF);
    regWrite(2'd0, 11'h0F3);
    pulseSet(11'h2C9);
    regRead(2'd1, d); check("R6 raw after set strobes", d, 11'h2C9);
    regRead(2'd2, d); check("R3 masked status", d, 11'h2C9 & 11'h0F3);
    settle();
    check("R8 R10 lines for mixed pattern", outLines(), expLines(11'h2C9, 11'h0F3));
  endtask

  task automatic t_routing();
    logic [10:0] d;
    regWrite(2'd0, 11'h7FF);
    for (int i = 0; i < 11; i++) begin
      regWrite(2'd3, 11'h7FF);
      settle();
      pulseSet(11'(1 << i));
      regRead(2'd1, d); check("R1 raw bit position", d, 11'(1 << i));
      check("R11 outputs lag one edge", outLines(), 11'h000);
      settle();
      check("R1 R9 R10 line routing", outLines(), expLines(11'(1 << i), 11'h7FF));
    end
  endtask

  task automatic t_clear();
    logic [10:0] d;
    pulseSet(11'h7FF);
    regWrite(2'd3, 11'h0F0);
    regRead(2'd1, d); check("R4 write-one-to-clear", d, 11'h70F);
    regRead(2'd3, d); check("R4 clear select reads zero", d, 11'h000);
  endtask

  task automatic t_ignored();
    logic [10:0] d;
    regWrite(2'd0, 11'h3C3);
    regWrite(2'd3, 11'h7FF);
    pulseSet(11'h155);
    regWrite(2'd1, 11'h000);
    regWrite(2'd2, 11'h7FF);
    regRead(2'd1, d); check("R5 raw unchanged by status writes", d, 11'h155);
    regRead(2'd0, d); check("R5 mask unchanged by status writes", d, 11'h3C3);
  endtask

  task automatic t_tx();
    logic [10:0] d;
    regWrite(2'd3, 11'h7FF);
    regWrite(2'd0, 11'h7FF);
    @(negedge clk); txDataWr = 1'b1;
    @(negedge clk); txDataWr = 1'b0;
    regRead(2'd1, d); check("R6 tx data write sets bit 5", d, 11'h020);
    settle();
    check("R9 irqTx from tx write", outLines(), expLines(11'h020, 11'h7FF));
  endtask

  task automatic t_collide();
    logic [10:0] d;
    regWrite(2'd3, 11'h7FF);
    pulseSet(11'h180);
    @(negedge clk);
    regWr = 1'b1; regSel = 2'd3; regWrData = 11'h180; evtSet = 11'h080;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0; evtSet = '0;
    regRead(2'd1, d); check("R7 set wins over clear", d, 11'h080);
    // mask write and new event in one cycle
    settle();
    @(negedge clk);
    regWr = 1'b1; regSel = 2'd0; regWrData = 11'h400; evtSet = 11'h400;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0; evtSet = '0;
    check("R11 outputs lag mask plus event", outLines(), expLines(11'h080, 11'h7FF));
    settle();
    check("R11 outputs after mask plus event", outLines(), expLines(11'h480, 11'h400));
  endtask

  task automatic t_maskgate();
    logic [10:0] d;
    pulseSet(11'h7FF);
    regWrite(2'd0, 11'h000);
    regRead(2'd2, d); check("R3 masked zero with empty mask", d, 11'h000);
    settle();
    check("R8 no line with empty mask", outLines(), 11'h000);
  endtask

  task automatic t_reset2();
    logic [10:0] d;
    regWrite(2'd0, 11'h7FF);
    pulseSet(11'h7FF);
    settle();
    check("R8 lines before reset", outLines(), expLines(11'h7FF, 11'h7FF));
    @(negedge clk); rstN = 1'b0;
    #1;
    regRead(2'd1, d); check("R12 raw cleared by reset", d, 11'h000);
    regRead(2'd0, d); check("R12 mask cleared by reset", d, 11'h000);
    check("R12 lines cleared by reset", outLines(), 11'h000);
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_events();
    t_routing();
    t_clear();
    t_ignored();
    t_tx();
    t_collide();
    t_maskgate();
    t_reset2();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule